// File: doc/BRIEF.md
# Video Capture Buffer Packer

This block takes a 16-bit parallel video stream and splits it across a small ring of DMA buffers. Each bus transfer carries two bytes. The stream is qualified by a frame-valid and a line-valid input. Every buffer keeps 12 bytes free at its start for a payload header and 4 bytes free at its end. The bytes between those two regions receive pixel words. The block emits one write per accepted word, giving the buffer index, the word address inside the buffer and the data.

A buffer is committed in two cases. The first is when its payload region is full. The second is when frame-valid falls with words still pending. A commit reports the buffer index and the byte count, and it flags a partial buffer. A committed buffer belongs to the consumer until the consumer asserts that buffer's release bit.

Writing a word into a buffer the consumer still holds is a commit failure. A frame that stays valid for too long is a timer overflow. Either case raises a one-cycle DMA-path reset event. After the event the block drops all input until the next frame start, and then resumes at buffer 0 with every buffer free. The two intended configurations are 2 buffers of 48 KiB and 3 buffers of 36 KiB, chosen by parameter. A 1920 x 1080 frame at 2 bytes per pixel is 0x3F4800 bytes.

Top module: `vcap_packer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, wrValid, commitValid, commitPartial, dmaResetEvt and commitBytes are all zero.
- R2: When frameValid and lineValid are both high at a clock edge, the word on pixData is written: wrValid is high after that edge, wrData equals the word, and wrAddr equals 6 plus the word's index within its buffer. Word 6 is the first word after the 12-byte header.
- R3: A buffer holds (BUF_BYTES-16)/2 words. The word whose index equals the limit ((BUF_BYTES-16)/2)-1 is written and committed at the same edge, with commitBytes = BUF_BYTES-16 and commitPartial low. For 48 KiB the limit is 24567, and for 36 KiB it is 18423.
- R4: Buffers are filled and committed in round-robin order 0, 1, ..., NUM_BUFS-1, 0. After any commit, the next word goes to the next buffer at wrAddr 6.
- R5: A falling frameValid with n > 0 words in the current buffer commits that buffer with commitPartial high and commitBytes = 2n. With n = 0, no commit takes place.
- R6: A committed buffer is held until bufRelease bit i is high at an edge. A word arriving for a held buffer is not written. It raises dmaResetEvt for exactly one cycle.
- R7: If frameValid is sampled high at more than FRAME_TIMEOUT consecutive edges, dmaResetEvt rises after the (FRAME_TIMEOUT+1)-th such edge.
- R8: After a reset event, no word is written and no commit is made until a rising frameValid. From that edge on, writing starts at buffer 0, wrAddr 6, with all buffers free.
- R9: The address count and the data count advance together and clear together at every buffer switch. At a full commit, the last written address is 6 plus the limit.
- R10: With lineValid low, no word is written, even while frameValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Frame qualifier |
| lineValid | input | 1 | Line qualifier |
| pixData | input | 16 | Two bytes of pixel data |
| bufRelease | input | NUM_BUFS | Per-buffer release from the consumer |
| wrValid | output | 1 | Word write strobe |
| wrBuf | output | idxW(NUM_BUFS) | Buffer receiving the word |
| wrAddr | output | addrW | Word address inside the buffer |
| wrData | output | 16 | Written word |
| commitValid | output | 1 | Buffer commit strobe |
| commitBuf | output | idxW(NUM_BUFS) | Committed buffer |
| commitBytes | output | byteW | Payload bytes in the committed buffer |
| commitPartial | output | 1 | Commit came from frame end before the buffer was full |
| dmaResetEvt | output | 1 | One-cycle DMA-path reset request |

## Verification
Every output is a register that is loaded from the inputs sampled at one rising edge. Writes, commits and the reset event therefore appear exactly one edge after the stimulus that causes them. This holds even for the timeout, which fires after the (FRAME_TIMEOUT+1)-th high sample. The bench changes inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge. It predicts each value from a running model of buffer index, word index, held set and frame timer. Commit bytes, buffer order and event counts are also recounted arithmetically after each frame.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef struct packed {
    logic wordWr;
    logic fullCommit;
    logic endCommit;
    logic pathReset;
  } vcapStrobe_t;

  function automatic int payWords(input int bufBytes, input int headBytes, input int tailBytes);
    return (bufBytes - headBytes - tailBytes) / 2;
  endfunction

  function automatic int idxW(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int addrW(input int bufBytes, input int headBytes, input int tailBytes);
    return $clog2(headBytes / 2 + payWords(bufBytes, headBytes, tailBytes));
  endfunction

  function automatic int byteW(input int bufBytes, input int headBytes, input int tailBytes);
    return $clog2(2 * payWords(bufBytes, headBytes, tailBytes) + 1);
  endfunction

endpackage

// File: rtl/vcap_datapath.sv
module vcap_datapath #(
  parameter int BUF_BYTES  = 49152,
  parameter int NUM_BUFS   = 2,
  parameter int HEAD_BYTES = 12,
  parameter int TAIL_BYTES = 4,
  localparam int PAY_WORDS  = vcap_pkg::payWords(BUF_BYTES, HEAD_BYTES, TAIL_BYTES),
  localparam int WORD_LIMIT = PAY_WORDS - 1,
  localparam int CNT_W      = vcap_pkg::idxW(PAY_WORDS),
  localparam int BUF_W      = vcap_pkg::idxW(NUM_BUFS),
  localparam int ADDR_W     = vcap_pkg::addrW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES),
  localparam int BYTE_W     = vcap_pkg::byteW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vcap_pkg::vcapStrobe_t  strb,
  input  logic [15:0]            pixData,
  output logic [BUF_W-1:0]       curBuf,
  output logic                   atLimit,
  output logic                   hasWords,
  output logic [CNT_W-1:0]       addrCnt,
  output logic [CNT_W-1:0]       dataCnt,
  output logic                   wrValid,
  output logic [BUF_W-1:0]       wrBuf,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [15:0]            wrData,
  output logic                   commitValid,
  output logic [BUF_W-1:0]       commitBuf,
  output logic [BYTE_W-1:0]      commitBytes,
  output logic                   commitPartial
);

  localparam int HEAD_WORDS = HEAD_BYTES / 2;

  logic [BUF_W-1:0] nextBuf;

  // ring advance: natural wrap for power-of-two rings, compare otherwise
  generate
    if ((1 << BUF_W) == NUM_BUFS) begin : g_pow2Ring
      assign nextBuf = curBuf + BUF_W'(1);
    end else begin : g_oddRing
      assign nextBuf = (curBuf == BUF_W'(NUM_BUFS - 1)) ? '0 : curBuf + BUF_W'(1);
    end
  endgenerate

  assign atLimit  = (addrCnt == CNT_W'(WORD_LIMIT));
  assign hasWords = (dataCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBuf        <= '0;
      addrCnt       <= '0;
      dataCnt       <= '0;
      wrValid       <= 1'b0;
      wrBuf         <= '0;
      wrAddr        <= '0;
      wrData        <= '0;
      commitValid   <= 1'b0;
      commitBuf     <= '0;
      commitBytes   <= '0;
      commitPartial <= 1'b0;
    end else begin
      wrValid       <= strb.wordWr;
      commitValid   <= strb.fullCommit | strb.endCommit;
      commitPartial <= strb.endCommit;
      if (strb.pathReset) begin
        curBuf  <= '0;
        addrCnt <= '0;
        dataCnt <= '0;
      end else begin
        if (strb.wordWr) begin
          wrBuf  <= curBuf;
          wrAddr <= ADDR_W'(HEAD_WORDS) + ADDR_W'(addrCnt);
          wrData <= pixData;
        end
        if (strb.fullCommit) begin
          commitBuf   <= curBuf;
          commitBytes <= (BYTE_W'(dataCnt) + BYTE_W'(1)) << 1;
          curBuf      <= nextBuf;
          addrCnt     <= '0;
          dataCnt     <= '0;
        end else if (strb.endCommit) begin
          commitBuf   <= curBuf;
          commitBytes <= BYTE_W'(dataCnt) << 1;
          curBuf      <= nextBuf;
          addrCnt     <= '0;
          dataCnt     <= '0;
        end else if (strb.wordWr) begin
          addrCnt <= addrCnt + CNT_W'(1);
          dataCnt <= dataCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/vcap_control.sv
module vcap_control #(
  parameter int NUM_BUFS      = 2,
  parameter int FRAME_TIMEOUT = 4000000,
  localparam int BUF_W        = vcap_pkg::idxW(NUM_BUFS),
  localparam int TMR_W        = $clog2(FRAME_TIMEOUT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameValid,
  input  logic                   lineValid,
  input  logic [NUM_BUFS-1:0]    bufRelease,
  input  logic [BUF_W-1:0]       curBuf,
  input  logic                   atLimit,
  input  logic                   hasWords,
  output vcap_pkg::vcapStrobe_t  strb,
  output logic                   dmaResetEvt
);

  logic                prevFv;
  logic                dropping;
  logic [NUM_BUFS-1:0] held;
  logic [NUM_BUFS-1:0] selMask;
  logic [TMR_W-1:0]    frameTimer;

  logic fvRise, fvFall, active, accept, timeout, heldCur, failCommit, evt;

  assign fvRise     = frameValid & ~prevFv;
  assign fvFall     = ~frameValid & prevFv;
  assign active     = ~dropping | fvRise;
  assign accept     = frameValid & lineValid & active;
  assign timeout    = frameValid & active & (frameTimer == TMR_W'(FRAME_TIMEOUT));
  assign heldCur    = |(held & selMask);
  assign failCommit = accept & heldCur;
  assign evt        = timeout | failCommit;

  always_comb begin
    strb            = '0;
    strb.pathReset  = evt;
    strb.wordWr     = accept & ~evt;
    strb.fullCommit = accept & ~evt & atLimit;
    strb.endCommit  = fvFall & ~dropping & hasWords;
  end

  // one ownership bit per buffer: commit takes it, release returns it
  generate
    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_own
      assign selMask[g] = (curBuf == BUF_W'(g));
      always_ff @(posedge clk) begin
        if (!rstN || evt) begin
          held[g] <= 1'b0;
        end else if ((strb.fullCommit | strb.endCommit) && selMask[g]) begin
          held[g] <= 1'b1;
        end else if (bufRelease[g]) begin
          held[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFv      <= 1'b0;
      dropping    <= 1'b0;
      frameTimer  <= '0;
      dmaResetEvt <= 1'b0;
    end else begin
      prevFv      <= frameValid;
      dmaResetEvt <= evt;
      if (evt) begin
        dropping <= 1'b1;
      end else if (fvRise) begin
        dropping <= 1'b0;
      end
      if (evt || !frameValid) begin
        frameTimer <= '0;
      end else if (active) begin
        frameTimer <= frameTimer + TMR_W'(1);
      end
    end
  end

endmodule

// File: rtl/vcap_packer.sv
module vcap_packer #(
  parameter int BUF_BYTES     = 49152,
  parameter int NUM_BUFS      = 2,
  parameter int HEAD_BYTES    = 12,
  parameter int TAIL_BYTES    = 4,
  parameter int FRAME_TIMEOUT = 4000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameValid,
  input  logic                lineValid,
  input  logic [15:0]         pixData,
  input  logic [NUM_BUFS-1:0] bufRelease,
  output logic                wrValid,
  output logic [vcap_pkg::idxW(NUM_BUFS)-1:0] wrBuf,
  output logic [vcap_pkg::addrW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES)-1:0] wrAddr,
  output logic [15:0]         wrData,
  output logic                commitValid,
  output logic [vcap_pkg::idxW(NUM_BUFS)-1:0] commitBuf,
  output logic [vcap_pkg::byteW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES)-1:0] commitBytes,
  output logic                commitPartial,
  output logic                dmaResetEvt
);

  localparam int PAY_WORDS = vcap_pkg::payWords(BUF_BYTES, HEAD_BYTES, TAIL_BYTES);
  localparam int CNT_W     = vcap_pkg::idxW(PAY_WORDS);
  localparam int BUF_W     = vcap_pkg::idxW(NUM_BUFS);

  vcap_pkg::vcapStrobe_t strb;
  logic [BUF_W-1:0]      curBuf;
  logic                  atLimit;
  logic                  hasWords;
  logic [CNT_W-1:0]      addrCnt;
  logic [CNT_W-1:0]      dataCnt;

  vcap_control #(
    .NUM_BUFS     (NUM_BUFS),
    .FRAME_TIMEOUT(FRAME_TIMEOUT)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .lineValid  (lineValid),
    .bufRelease (bufRelease),
    .curBuf     (curBuf),
    .atLimit    (atLimit),
    .hasWords   (hasWords),
    .strb       (strb),
    .dmaResetEvt(dmaResetEvt)
  );

  vcap_datapath #(
    .BUF_BYTES (BUF_BYTES),
    .NUM_BUFS  (NUM_BUFS),
    .HEAD_BYTES(HEAD_BYTES),
    .TAIL_BYTES(TAIL_BYTES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .pixData      (pixData),
    .curBuf       (curBuf),
    .atLimit      (atLimit),
    .hasWords     (hasWords),
    .addrCnt      (addrCnt),
    .dataCnt      (dataCnt),
    .wrValid      (wrValid),
    .wrBuf        (wrBuf),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .commitValid  (commitValid),
    .commitBuf    (commitBuf),
    .commitBytes  (commitBytes),
    .commitPartial(commitPartial)
  );

endmodule

// File: rtl/vcap_packer_chk.sv
module vcap_packer_chk #(
  parameter int BUF_BYTES  = 49152,
  parameter int HEAD_BYTES = 12,
  parameter int TAIL_BYTES = 4,
  localparam int PAY_WORDS = vcap_pkg::payWords(BUF_BYTES, HEAD_BYTES, TAIL_BYTES),
  localparam int CNT_W     = vcap_pkg::idxW(PAY_WORDS),
  localparam int ADDR_W    = vcap_pkg::addrW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES),
  localparam int BYTE_W    = vcap_pkg::byteW(BUF_BYTES, HEAD_BYTES, TAIL_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              commitValid,
  input logic              commitPartial,
  input logic [BYTE_W-1:0] commitBytes,
  input logic              dmaResetEvt,
  input logic [CNT_W-1:0]  addrCnt,
  input logic [CNT_W-1:0]  dataCnt
);

  localparam int HEAD_WORDS = HEAD_BYTES / 2;

  // R9
  lockstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt == dataCnt);

  // R3
  full_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !commitPartial) |-> commitBytes == BYTE_W'(2 * PAY_WORDS));

  // R5
  partial_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPartial |-> (commitValid && commitBytes != '0 && commitBytes < BYTE_W'(2 * PAY_WORDS)));

  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr >= ADDR_W'(HEAD_WORDS) && wrAddr <= ADDR_W'(HEAD_WORDS + PAY_WORDS - 1)));

  // R6
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaResetEvt |-> !wrValid);

  // R8
  drop_after_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaResetEvt |=> (!wrValid && !commitValid && !dmaResetEvt));

endmodule

bind vcap_packer vcap_packer_chk #(
  .BUF_BYTES (BUF_BYTES),
  .HEAD_BYTES(HEAD_BYTES),
  .TAIL_BYTES(TAIL_BYTES)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .wrValid      (wrValid),
  .wrAddr       (wrAddr),
  .commitValid  (commitValid),
  .commitPartial(commitPartial),
  .commitBytes  (commitBytes),
  .dmaResetEvt  (dmaResetEvt),
  .addrCnt      (addrCnt),
  .dataCnt      (dataCnt)
);

// File: tb/vcap_packer_tb.sv
`timescale 1ns/1ps
module vcap_packer_tb_top;

  localparam int BUF_BYTES = 32;
  localparam int NB        = 3;
  localparam int TO        = 200;
  localparam int PAY       = (BUF_BYTES - 16) / 2;
  localparam int LIM       = PAY - 1;
  localparam int HW        = 6;
  localparam int BUF_W     = vcap_pkg::idxW(NB);
  localparam int ADDR_W    = vcap_pkg::addrW(BUF_BYTES, 12, 4);
  localparam int BYTE_W    = vcap_pkg::byteW(BUF_BYTES, 12, 4);

  logic clk = 1'b0;
  logic rstN;
  logic frameValid, lineValid;
  logic [15:0] pixData;
  logic [NB-1:0] bufRelease;
  logic wrValid, commitValid, commitPartial, dmaResetEvt;
  logic [BUF_W-1:0] wrBuf, commitBuf;
  logic [ADDR_W-1:0] wrAddr;
  logic [15:0] wrData;
  logic [BYTE_W-1:0] commitBytes;

  always #4 clk = ~clk;

  vcap_packer #(
    .BUF_BYTES(BUF_BYTES), .NUM_BUFS(NB), .HEAD_BYTES(12), .TAIL_BYTES(4), .FRAME_TIMEOUT(TO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
    .pixData(pixData), .bufRelease(bufRelease), .wrValid(wrValid), .wrBuf(wrBuf),
    .wrAddr(wrAddr), .wrData(wrData), .commitValid(commitValid), .commitBuf(commitBuf),
    .commitBytes(commitBytes), .commitPartial(commitPartial), .dmaResetEvt(dmaResetEvt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit mPrevFv, mDrop;
  bit [NB-1:0] mHeld;
  int mBuf, mIdx, mTimer;
  bit autoRel;
  bit [NB-1:0] pendRel;
  logic [15:0] dataSeq = 16'h1000;

  // observed statistics
  int nWr, nFull, nPart, nEvt, lastPartBytes, nSeq;
  int seqBuf [0:31];
  bit markFirst;
  int firstWrBuf, firstWrAddr;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPrevFv = 0; mDrop = 0; mHeld = '0; mBuf = 0; mIdx = 0; mTimer = 0; pendRel = '0;
  endtask

  task automatic step(input bit fv, input bit lv, input bit [NB-1:0] rel, input string tag);
    bit [NB-1:0] relUsed;
    bit fvRise, fvFall, active, accept, timeout, fail, evt, expWr, expFull, expEnd;
    logic [15:0] d;
    relUsed = rel | (autoRel ? pendRel : '0);
    pendRel = '0;
    fvRise  = fv && !mPrevFv;
    fvFall  = !fv && mPrevFv;
    active  = !mDrop || fvRise;
    accept  = fv && lv && active;
    timeout = fv && active && (mTimer == TO);
    fail    = accept && mHeld[mBuf];
    evt     = timeout || fail;
    expWr   = accept && !evt;
    expFull = expWr && (mIdx == LIM);
    expEnd  = fvFall && !mDrop && (mIdx != 0);
    d = dataSeq;
    dataSeq = dataSeq + 16'd1;
    frameValid = fv; lineValid = lv; pixData = d; bufRelease = relUsed;
    @(negedge clk);
    chk(tag, "wrValid", wrValid, expWr);
    if (expWr) begin
      chk("R4", "wrBuf", wrBuf, mBuf);
      chk("R2", "wrAddr", wrAddr, HW + mIdx);
      chk("R2", "wrData", wrData, d);
    end
    chk(tag, "commitValid", commitValid, expFull || expEnd);
    chk("R5", "commitPartial", commitPartial, expEnd);
    if (expFull || expEnd) begin
      chk("R4", "commitBuf", commitBuf, mBuf);
      chk(expFull ? "R3" : "R5", "commitBytes", commitBytes, expFull ? 2 * PAY : 2 * mIdx);
    end
    if (expFull) chk("R9", "last address at full commit", wrAddr, HW + LIM);
    chk(tag, "dmaResetEvt", dmaResetEvt, evt);
    // statistics from the ports
    if (wrValid) begin
      nWr++;
      if (markFirst) begin
        firstWrBuf = wrBuf; firstWrAddr = wrAddr; markFirst = 0;
      end
    end
    if (commitValid && !commitPartial) nFull++;
    if (commitPartial) begin
      nPart++; lastPartBytes = commitBytes;
    end
    if (commitValid) begin
      if (nSeq < 32) seqBuf[nSeq] = commitBuf;
      nSeq++;
      if (autoRel) pendRel[commitBuf] = 1'b1;
    end
    if (dmaResetEvt) nEvt++;
    // advance reference state
    if (evt) begin
      mHeld = '0; mBuf = 0; mIdx = 0; mDrop = 1; mTimer = 0;
    end else begin
      mHeld = mHeld & ~relUsed;
      if (expFull || expEnd) begin
        mHeld[mBuf] = 1'b1;
        mBuf = (mBuf + 1) % NB;
        mIdx = 0;
      end else if (expWr) begin
        mIdx++;
      end
      if (fvRise) mDrop = 0;
      if (!fv) mTimer = 0;
      else if (active) mTimer++;
    end
    mPrevFv = fv;
  endtask

  task automatic frame(input int nLines, input int wpl, input int gap, input string tag);
    step(1, 0, '0, tag);
    for (int l = 0; l < nLines; l++) begin
      for (int w = 0; w < wpl; w++) step(1, 1, '0, tag);
      for (int g = 0; g < gap; g++) step(1, 0, '0, "R10");
    end
    step(0, 0, '0, tag);
    for (int i = 0; i < 3; i++) step(0, 0, '0, tag);
  endtask

  task automatic resetDut();
    rstN = 0; frameValid = 0; lineValid = 0; pixData = '0; bufRelease = '0;
    repeat (3) @(negedge clk);
    chk("R1", "wrValid in reset", wrValid, 0);
    chk("R1", "commitValid in reset", commitValid, 0);
    chk("R1", "commitPartial in reset", commitPartial, 0);
    chk("R1", "dmaResetEvt in reset", dmaResetEvt, 0);
    chk("R1", "commitBytes in reset", commitBytes, 0);
    rstN = 1;
    modelReset();
    step(0, 0, '0, "R1");
  endtask

  initial begin
    int w0, f0, p0, e0;
    rstN = 0;
    autoRel = 1;
    resetDut();

    // sweep of single-line frame lengths, consumer releases at once
    for (int n = 1; n <= 20; n++) begin
      w0 = nWr; f0 = nFull; p0 = nPart;
      frame(1, n, 2, "R5");
      chk("R3", "full commits per frame", nFull - f0, n / PAY);
      chk("R5", "partial commits per frame", nPart - p0, (n % PAY) != 0);
      if (n % PAY != 0) chk("R5", "partial bytes", lastPartBytes, 2 * (n % PAY));
      chk("R10", "words written", nWr - w0, n);
    end

    // multi-line frame with blanking between lines
    w0 = nWr; f0 = nFull; p0 = nPart;
    frame(3, 10, 4, "R10");
    chk("R10", "words with blanking", nWr - w0, 30);
    chk("R3", "full commits in 30 words", nFull - f0, 3);
    chk("R5", "tail bytes of 30 words", lastPartBytes, 12);

    // ring order
    resetDut();
    nSeq = 0;
    frame(1, 40, 0, "R4");
    chk("R4", "commit count", nSeq, 5);
    for (int k = 0; k < 5; k++) chk("R4", "commit order", seqBuf[k], k % NB);

    // consumer never releases: fourth buffer start fails
    resetDut();
    autoRel = 0;
    w0 = nWr; e0 = nEvt; f0 = nFull;
    frame(1, 30, 0, "R6");
    chk("R6", "events on held buffer", nEvt - e0, 1);
    chk("R6", "words before failure", nWr - w0, 3 * PAY);
    chk("R6", "full commits before failure", nFull - f0, 3);
    w0 = nWr; e0 = nEvt; markFirst = 1;
    frame(1, 5, 0, "R8");
    chk("R8", "first buffer after event", firstWrBuf, 0);
    chk("R8", "first address after event", firstWrAddr, HW);
    chk("R8", "no event after restart", nEvt - e0, 0);
    chk("R8", "bytes after restart", lastPartBytes, 10);

    // explicit release lets a buffer be reused
    resetDut();
    e0 = nEvt; f0 = nFull;
    frame(1, 3 * PAY, 0, "R6");
    step(0, 0, 3'b001, "R6");
    frame(1, PAY, 0, "R6");
    chk("R6", "released buffer reused", nEvt - e0, 0);
    chk("R6", "commits with release", nFull - f0, 4);
    w0 = nWr;
    frame(1, 1, 0, "R6");
    chk("R6", "held buffer rejects word", nEvt - e0, 1);
    chk("R6", "no write into held buffer", nWr - w0, 0);

    // frame timer
    resetDut();
    autoRel = 1;
    e0 = nEvt;
    for (int i = 0; i < TO; i++) step(1, 0, '0, "R7");
    step(0, 0, '0, "R7");
    chk("R7", "no event at the limit", nEvt - e0, 0);
    for (int i = 0; i < TO; i++) step(1, 0, '0, "R7");
    step(1, 0, '0, "R7");
    chk("R7", "event after limit+1 samples", dmaResetEvt, 1);
    w0 = nWr;
    for (int i = 0; i < 5; i++) step(1, 1, '0, "R8");
    chk("R8", "words dropped after timeout", nWr - w0, 0);
    step(0, 0, '0, "R8");
    markFirst = 1;
    frame(1, 3, 0, "R8");
    chk("R8", "restart buffer", firstWrBuf, 0);
    chk("R8", "restart address", firstWrAddr, HW);
    chk("R8", "restart bytes", lastPartBytes, 6);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule